// File: doc/BRIEF.md
# E1 Receive Spare-Bit Capture

This block sits behind an E1 receive framer that has already found frame and CRC-4 multiframe alignment. Each time the framer presents the channel-zero byte of a frame, it also gives the frame's position within the multiframe (0 to 15). The block keeps only the odd frames, which carry the national (spare) bits Sa4 to Sa8. It sorts those bits into five bytes, one for each Sa position. Each byte holds that position's bit from all eight odd frames of one multiframe.

Bits gather in a shadow store while the multiframe is still arriving. The store is copied into the readable bytes when frame 15 is captured. A processor reading between two copies always sees one complete multiframe, never a mix of two. A read port with an address selects one byte at a time.

When frame 0 of a multiframe is received, the block pulses a status flag and sets a pending interrupt. The interrupt stays set until it is cleared. A mask blocks only the interrupt output and leaves the pending state untouched. While the alignment input is low, nothing is captured and no flag is raised.

Top module: `e1_natbit_rx`

## Requirements
- R1: While `rst_n` is low and right after it rises, `rd_data` reads 0 at every address, and `mf_flag` and `irq` are 0.
- R2: On a strobe with an odd `frame_num` and `align_ok` high, the block takes Sa4, Sa5, Sa6, Sa7 and Sa8 from `ts0_byte` bits 4, 3, 2, 1 and 0. Bit 7 of `ts0_byte` is channel bit 1.
- R3: Address 0 to 4 reads the byte for Sa4 to Sa8. Within a byte, bit 7 holds frame 1, bit 6 holds frame 3, and so on down to bit 0, which holds frame 15.
- R4: Strobes with an even `frame_num` have no effect on the captured bits.
- R5: The readable bytes change only at the clock edge that captures frame 15, and they then hold all eight odd frames of that multiframe. Reads before that edge return the previous multiframe.
- R6: While `align_ok` is low, strobes capture nothing, cause no copy into the readable bytes, and raise no flag.
- R7: `mf_flag` is high for exactly the one cycle after the edge that took a strobe with `frame_num` = 0 and `align_ok` high.
- R8: A multiframe start sets the pending interrupt. The pending interrupt stays set until `irq_clear` is sampled high. When a start and a clear arrive in the same cycle, the start wins.
- R9: `irq` equals the pending interrupt when `irq_mask` is low and is 0 when `irq_mask` is high. If a start arrives while the mask is high, `irq` rises once the mask is removed.
- R10: Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| align_ok | input | 1 | Framer reports frame and multiframe alignment |
| ts0_strobe | input | 1 | Channel-zero byte and frame number are valid this cycle |
| ts0_byte | input | 8 | Received channel-zero byte, bit 7 = channel bit 1 |
| frame_num | input | 4 | Frame position in the CRC-4 multiframe, 0 to 15 |
| irq_mask | input | 1 | High blocks the interrupt output |
| irq_clear | input | 1 | High clears the pending interrupt |
| rd_addr | input | 3 | Read byte select, 0 = Sa4 … 4 = Sa8 |
| rd_data | output | 8 | Selected byte, bit 7 = frame 1 |
| mf_flag | output | 1 | One-cycle multiframe-start status |
| irq | output | 1 | Masked, latched multiframe-start interrupt |

## Verification
A shadow bit stored in the wrong slot, or taken from an even frame, cannot be seen until the next frame-15 copy. At that point it appears as a wrong bit at one particular address and bit position, so the bench reads every address after every multiframe. A copy made at the wrong time shows up within a single frame as a change in `rd_data` in the middle of a multiframe. Faults in the pending interrupt show up on `irq` in the cycle after a start, a clear or a mask change.

// File: rtl/e1nb_pkg.sv
package e1nb_pkg;
  localparam int FRAMES_PER_MF = 16;
  localparam int FRAME_W       = $clog2(FRAMES_PER_MF);
  localparam int SLOTS         = FRAMES_PER_MF / 2;
  localparam int SLOT_W        = $clog2(SLOTS);
  localparam int SA_TOP_POS    = 4;   // Sa4 sits at byte bit 4, Sa8 at bit 0

  // Odd frames carry the spare bits.
  function automatic logic is_spare_frame(input logic [FRAME_W-1:0] fn);
    return fn[0];
  endfunction

  // Frame 1 -> bit SLOTS-1, frame 15 -> bit 0.
  function automatic logic [SLOT_W-1:0] slot_of(input logic [FRAME_W-1:0] fn);
    return ~fn[FRAME_W-1:1];
  endfunction

  function automatic logic is_last_frame(input logic [FRAME_W-1:0] fn);
    return fn == FRAME_W'(FRAMES_PER_MF - 1);
  endfunction

  function automatic logic is_first_frame(input logic [FRAME_W-1:0] fn);
    return fn == '0;
  endfunction
endpackage

// File: rtl/e1nb_shadow.sv
module e1nb_shadow
  import e1nb_pkg::*;
#(
  parameter int NUM_SA = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic [SLOT_W-1:0]       slot,
  input  logic [7:0]              chan_byte,
  output logic [NUM_SA*SLOTS-1:0] merged
);
  logic [NUM_SA*SLOTS-1:0] shadow_q;

  for (genvar s = 0; s < NUM_SA; s++) begin : g_sa
    for (genvar t = 0; t < SLOTS; t++) begin : g_slot
      assign merged[s*SLOTS+t] = (take && slot == SLOT_W'(t)) ? chan_byte[SA_TOP_POS-s]
                                                               : shadow_q[s*SLOTS+t];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= merged;
  end
endmodule

// File: rtl/e1nb_rdbuf.sv
module e1nb_rdbuf
  import e1nb_pkg::*;
#(
  parameter int NUM_SA = 5,
  parameter int ADDR_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  logic [NUM_SA*SLOTS-1:0] merged,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [SLOTS-1:0]        rd_data
);
  logic [NUM_SA*SLOTS-1:0] vis_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      vis_q <= '0;
    else if (commit) vis_q <= merged;
  end

  always_comb begin
    rd_data = '0;
    for (int s = 0; s < NUM_SA; s++)
      if (rd_addr == ADDR_W'(s)) rd_data = vis_q[s*SLOTS +: SLOTS];
  end
endmodule

// File: rtl/e1nb_mfevt.sv
module e1nb_mfevt (
  input  logic clk,
  input  logic rst_n,
  input  logic mf_begin,
  input  logic irq_mask,
  input  logic irq_clear,
  output logic mf_flag,
  output logic irq_pend,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mf_flag  <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      mf_flag <= mf_begin;
      if (mf_begin)       irq_pend <= 1'b1;
      else if (irq_clear) irq_pend <= 1'b0;
    end
  end

  assign irq = irq_pend & ~irq_mask;
endmodule

// File: rtl/e1_natbit_rx.sv
module e1_natbit_rx
  import e1nb_pkg::*;
#(
  parameter int NUM_SA = 5,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               align_ok,
  input  logic               ts0_strobe,
  input  logic [7:0]         ts0_byte,
  input  logic [FRAME_W-1:0] frame_num,
  input  logic               irq_mask,
  input  logic               irq_clear,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [SLOTS-1:0]   rd_data,
  output logic               mf_flag,
  output logic               irq
);
  logic                    live;
  logic                    take;
  logic                    commit;
  logic                    mf_begin;
  logic                    irq_pend;
  logic [NUM_SA*SLOTS-1:0] merged;

  assign live     = ts0_strobe & align_ok;
  assign take     = live & is_spare_frame(frame_num);
  assign commit   = take & is_last_frame(frame_num);
  assign mf_begin = live & is_first_frame(frame_num);

  e1nb_shadow #(.NUM_SA(NUM_SA)) u_shadow (
    .clk(clk), .rst_n(rst_n), .take(take), .slot(slot_of(frame_num)),
    .chan_byte(ts0_byte), .merged(merged)
  );

  e1nb_rdbuf #(.NUM_SA(NUM_SA), .ADDR_W(ADDR_W)) u_rdbuf (
    .clk(clk), .rst_n(rst_n), .commit(commit), .merged(merged),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  e1nb_mfevt u_evt (
    .clk(clk), .rst_n(rst_n), .mf_begin(mf_begin), .irq_mask(irq_mask),
    .irq_clear(irq_clear), .mf_flag(mf_flag), .irq_pend(irq_pend), .irq(irq)
  );
endmodule

// File: rtl/e1nb_checker.sv
module e1nb_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       align_ok,
  input logic       ts0_strobe,
  input logic [3:0] frame_num,
  input logic       irq_mask,
  input logic       irq_clear,
  input logic [2:0] rd_addr,
  input logic [7:0] rd_data,
  input logic       mf_flag,
  input logic       irq,
  input logic       take,
  input logic       commit,
  input logic       irq_pend
);
  p_flag_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mf_flag |-> $past(ts0_strobe && align_ok && frame_num == 4'd0));

  p_copy_needs_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (align_ok && take));

  p_view_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!commit) && $stable(rd_addr)) |-> $stable(rd_data));

  p_start_sets_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mf_flag |-> irq_pend);

  p_pend_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_clear) |=> irq_pend);

  p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq);

  p_unmasked_shows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !irq_mask) |-> irq);
endmodule

bind e1_natbit_rx e1nb_checker u_chk (.*);

// File: tb/e1_natbit_rx_test.sv
module e1_natbit_rx_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       align_ok = 1'b0;
  logic       ts0_strobe = 1'b0;
  logic [7:0] ts0_byte = '0;
  logic [3:0] frame_num = '0;
  logic       irq_mask = 1'b0;
  logic       irq_clear = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       mf_flag;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_natbit_rx uut (
    .clk(clk), .rst_n(rst_n), .align_ok(align_ok), .ts0_strobe(ts0_strobe),
    .ts0_byte(ts0_byte), .frame_num(frame_num), .irq_mask(irq_mask),
    .irq_clear(irq_clear), .rd_addr(rd_addr), .rd_data(rd_data),
    .mf_flag(mf_flag), .irq(irq)
  );

  function automatic logic [7:0] pat(int m, int f);
    return 8'((m*37 + f*11 + 5) ^ (f*16) ^ (m*64));
  endfunction

  // Expected byte for address a after multiframe m (R2, R3, R10).
  function automatic logic [7:0] expect_byte(int m, int a);
    logic [7:0] r = '0;
    if (a > 4) return '0;
    for (int f = 1; f < 16; f += 2) begin
      logic [7:0] b = pat(m, f);
      r[7 - (f-1)/2] = b[4 - a];
    end
    return r;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(int f, logic [7:0] b, logic al, logic clr);
    @(negedge clk);
    ts0_strobe = 1'b1; frame_num = 4'(f); ts0_byte = b; align_ok = al; irq_clear = clr;
    @(negedge clk);
    ts0_strobe = 1'b0; irq_clear = 1'b0; ts0_byte = 8'hA5;
  endtask

  task automatic check_all(string req, int m);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a);
      #1;
      chk(req, rd_data, expect_byte(m, a));
    end
  endtask

  task automatic run_mf(int m, logic al, logic clr0);
    for (int f = 0; f < 16; f++) begin
      send(f, pat(m, f), al, (f == 0) ? clr0 : 1'b0);
      if (f == 0) chk(al ? "R7 flag after frame 0" : "R6 no flag unaligned", mf_flag, al);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk); irq_clear = 1'b1;
    @(negedge clk); irq_clear = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1; chk("R1 reset read", rd_data, 0);
    end
    chk("R1 reset flag", mf_flag, 0);
    chk("R1 reset irq", irq, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset irq", irq, 0);

    // Multiframe 0, checked part way through and at its end.
    for (int f = 0; f < 16; f++) begin
      send(f, pat(0, f), 1'b1, 1'b0);
      if (f == 0) begin
        chk("R7 flag", mf_flag, 1);
        chk("R8 irq set", irq, 1);
        @(negedge clk);
        chk("R7 flag one cycle", mf_flag, 0);
      end
      if (f == 7)  begin rd_addr = 3'd0; #1; chk("R5 no early copy", rd_data, 0); end
      if (f == 14) begin rd_addr = 3'd4; #1; chk("R5 no copy before 15", rd_data, 0); end
    end
    check_all("R2 R3 R4 R10 multiframe 0", 0);
    repeat (4) @(negedge clk);
    chk("R8 irq held", irq, 1);
    pulse_clear();
    chk("R8 irq cleared", irq, 0);

    // Masked start, previous contents visible mid-frame.
    irq_mask = 1'b1;
    for (int f = 0; f < 16; f++) begin
      send(f, pat(1, f), 1'b1, 1'b0);
      if (f == 0) chk("R9 masked irq", irq, 0);
      if (f == 9) check_all("R5 previous multiframe", 0);
    end
    check_all("R5 copy multiframe 1", 1);
    @(negedge clk); irq_mask = 1'b0; #1;
    chk("R9 unmask shows pending", irq, 1);
    pulse_clear();
    chk("R8 clear after unmask", irq, 0);

    // Alignment lost for a whole multiframe.
    run_mf(2, 1'b0, 1'b0);
    chk("R6 no irq unaligned", irq, 0);
    check_all("R6 no capture unaligned", 1);

    // Start and clear together: start wins.
    run_mf(3, 1'b1, 1'b1);
    chk("R8 set beats clear", irq, 1);
    check_all("R2 R3 multiframe 3", 3);
    pulse_clear();

    // Sweep of further patterns.
    for (int m = 4; m < 12; m++) begin
      run_mf(m, 1'b1, 1'b0);
      check_all("R2 R3 R4 sweep", m);
      pulse_clear();
      chk("R8 sweep clear", irq, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule